// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial transmit line of a UART into the return-to-zero pulse stream that an infrared LED driver expects. A high line (mark) sends nothing. A low bit (space) sends one short pulse, placed near the middle of its bit cell. Bit cells are timed by a one-cycle strobe that fires sixteen times per bit. The block runs on a faster crystal clock, and the strobe marks which crystal edges count as steps of the bit-rate clock.

There are two output shapes. In the default shape the pulse lasts three strobe periods, which is 3/16 of a bit, and it starts seven strobe periods into the cell. In the short shape each pulse lasts a fixed number of crystal cycles whatever the bit rate, which saves LED current at slow rates. The short shape only applies when the strobe comes from the on-chip divider. When the strobe is supplied from outside, the shape select is ignored.

The serial input passes through a two-flop synchronizer before its falling edge is detected. A falling edge is remembered until the next strobe, so that cell timing always lines up with the strobe.

Top module: `sir_pulse_enc`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, and on the edge after it, `ir_out` is 0. With `ser_in` held high after reset, `ir_out` stays 0.
- R2: Default shape. Let f be the first clock edge that samples `ser_in` low after it was high. Let T be the first edge at or after f+2 on which `tick16` is 1. Then `ir_out` is 1 for exactly 3 strobe periods, beginning after edge T + 7·P + 1, where P is the number of clocks between strobes. Outside that window `ir_out` is 0.
- R3: If `ser_in` is still low at the 16th strobe after a cell started, a new cell starts on that strobe. Pulses of consecutive spaces therefore start exactly 16 strobe periods apart.
- R4: A mark bit (`ser_in` high at the cell boundary) produces no pulse and returns the encoder to idle. The number of pulses in a frame equals the number of space bits.
- R5: Short shape (`short_mode`=1 and `int_src`=1). Each pulse starts on the same edge as in R2 and lasts exactly 6 clock cycles, for any strobe period.
- R6: When `int_src`=0, `short_mode` has no effect and the output follows R2.
- R7: Asserting `rst` in the middle of a pulse drives `ir_out` to 0 on the next edge. After release with `ser_in` high, no further pulse appears.
- R8: A falling edge of `ser_in` is acted on only at a strobe. An edge that arrives between strobes is held until the next one, so the pulse position depends on the strobe phase as stated in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle strobe, 16 per bit time |
| ser_in | input | 1 | UART serial transmit data, idle high |
| short_mode | input | 1 | 1 selects the fixed-width short pulse |
| int_src | input | 1 | 1 when the strobe comes from the internal divider |
| ir_out | output | 1 | Encoded infrared pulse output |

## Verification
Two events can land on the same crystal edge: the detection of a new falling edge on the serial line, and the strobe that closes the current bit cell. Likewise, a falling edge can coincide with the strobe that starts a cell from idle. The bench provokes both by shifting the idle gap before each frame, across strobe periods of 1, 2 and 3 clocks, so that the synchronized edge meets every strobe phase. For every clock cycle it compares `ir_out` against a window computed from the strobe arithmetic, and it checks the edge on which the first pulse rises.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

    localparam int DEF_CELL_LEN = 16;
    localparam int DEF_LEAD     = 7;
    localparam int DEF_WIDTH    = 3;
    localparam int DEF_SHOT_LEN = 6;
    localparam int DEF_SYNC     = 2;

    typedef enum logic {
        SHAPE_SPAN = 1'b0,
        SHAPE_SHOT = 1'b1
    } shape_e;

    function automatic logic in_window(input int pos, input int lead, input int width);
        return (pos >= lead) && (pos < lead + width);
    endfunction

endpackage

// File: rtl/sir_in_sync.sv
module sir_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dsync,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prior;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b1;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prior <= 1'b1;
        else     prior <= chain[STAGES-1];
    end

    assign dsync = chain[STAGES-1];
    assign fall  = prior & ~chain[STAGES-1];

    p_fall_single_r8: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/sir_cell_seq.sv
module sir_cell_seq
    import sir_enc_pkg::*;
#(
    parameter int CELL_LEN = DEF_CELL_LEN,
    parameter int LEAD     = DEF_LEAD,
    parameter int WIDTH    = DEF_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dsync,
    input  logic fall,
    output logic raw
);
    localparam int CNT_W = $clog2(CELL_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st;
    logic want;

    assign want = st.pend | fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!tick) begin
            st.pend <= want;
        end else if (!st.busy) begin
            if (want) begin
                st.busy <= 1'b1;
                st.cnt  <= '0;
                st.pend <= 1'b0;
            end
        end else if (st.cnt == LAST) begin
            if (!dsync || want) begin
                st.cnt  <= '0;
                st.pend <= 1'b0;
            end else begin
                st.busy <= 1'b0;
                st.pend <= 1'b0;
            end
        end else begin
            st.cnt  <= st.cnt + 1'b1;
            st.pend <= want;
        end
    end

    assign raw = st.busy && in_window(int'(st.cnt), LEAD, WIDTH);

    // R3: the position counter only moves on a strobe
    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !tick) |=> (st.busy && $stable(st.cnt)));

    // R3: a space still present at the boundary opens a fresh cell
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (st.busy && tick && st.cnt == LAST && !dsync) |=> (st.busy && st.cnt == '0));

    // R4: a mark at the boundary with no pending edge ends the sequence
    p_mark_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (st.busy && tick && st.cnt == LAST && dsync && !want) |=> !st.busy);

endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper
    import sir_enc_pkg::*;
#(
    parameter int SHOT_LEN = DEF_SHOT_LEN
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   raw,
    input  shape_e shape,
    output logic   pulse
);
    localparam int SH_W = $clog2(SHOT_LEN + 1);

    logic            raw_d;
    logic            rise;
    logic [SH_W-1:0] left;

    assign rise = raw & ~raw_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_d <= 1'b0;
            left  <= '0;
            pulse <= 1'b0;
        end else begin
            raw_d <= raw;
            if (shape == SHAPE_SHOT) begin
                if (rise)            left <= SH_W'(SHOT_LEN - 1);
                else if (left != '0) left <= left - 1'b1;
                pulse <= rise | (left != '0);
            end else begin
                left  <= '0;
                pulse <= raw;
            end
        end
    end

    // R5: a new shot never starts while the previous one is running
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        (shape == SHAPE_SHOT && rise) |-> (left == '0));

endmodule

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc
    import sir_enc_pkg::*;
#(
    parameter int CELL_LEN    = DEF_CELL_LEN,
    parameter int LEAD        = DEF_LEAD,
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SHOT_LEN    = DEF_SHOT_LEN,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic tick16,
    input  logic ser_in,
    input  logic short_mode,
    input  logic int_src,
    output logic ir_out
);
    logic   dsync;
    logic   fall;
    logic   raw;
    shape_e shape;

    assign shape = (short_mode && int_src) ? SHAPE_SHOT : SHAPE_SPAN;

    sir_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (ser_in),
        .dsync (dsync),
        .fall  (fall)
    );

    sir_cell_seq #(
        .CELL_LEN (CELL_LEN),
        .LEAD     (LEAD),
        .WIDTH    (WIDTH)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .dsync (dsync),
        .fall  (fall),
        .raw   (raw)
    );

    sir_pulse_shaper #(
        .SHOT_LEN (SHOT_LEN)
    ) u_shape (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw),
        .shape (shape),
        .pulse (ir_out)
    );

    // R1, R7: reset clears the output on the following edge
    p_reset_low_r7: assert property (@(posedge clk)
        rst |=> !ir_out);

endmodule

// File: tb/sim_sir_pulse_enc.sv
`timescale 1ns/1ps
module sim_sir_pulse_enc;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic ser_in = 1'b1;
    logic short_mode = 1'b0;
    logic int_src = 1'b0;
    logic ir_out;

    int total = 0;
    int bad = 0;
    int n = 0;
    int cur_div = 1;
    logic [9:0] bits;
    bit done = 0;

    always #2.5 clk = ~clk;

    sir_pulse_enc u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .ser_in(ser_in),
        .short_mode(short_mode), .int_src(int_src), .ir_out(ir_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        tick16 = ((n + 1) % cur_div == 0);
        @(posedge clk);
        n++;
        #1;
    endtask

    function automatic logic expect_at(input int e, input int t0, input int div, input bit mono);
        int s;
        int w;
        w = mono ? 6 : 3 * div;
        for (int j = 0; j < 10; j++) begin
            if (bits[j] == 1'b0) begin
                s = t0 + 16 * div * j + 7 * div + 1;
                if (e >= s && e < s + w) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic run_frame(input logic [7:0] data, input int div, input bit pm,
                             input bit isrc, input int gap);
        int f;
        int t0;
        int stop_at;
        int miss = 0;
        int rises = 0;
        int zeros = 0;
        int first = -1;
        logic prev = 1'b0;
        bit mono;
        string tag;
        cur_div = div;
        short_mode = pm;
        int_src = isrc;
        mono = pm && isrc;
        bits = {1'b1, data, 1'b0};
        for (int j = 0; j < 10; j++) if (bits[j] == 1'b0) zeros++;
        ser_in = 1'b1;
        for (int i = 0; i < gap; i++) step();
        f = n + 1;
        t0 = f + 2;
        while (t0 % div != 0) t0++;
        stop_at = f + 160 * div + 4 * div + 30;
        while (n < stop_at) begin
            if (ir_out !== expect_at(n, t0, div, mono)) miss++;
            if (ir_out === 1'b1 && prev === 1'b0) begin
                rises++;
                if (first < 0) first = n;
            end
            prev = ir_out;
            if (n + 1 < f || (n + 1 - f) / (16 * div) >= 10) ser_in = 1'b1;
            else ser_in = bits[(n + 1 - f) / (16 * div)];
            step();
        end
        // R5 short shape, R6 select ignored on external strobe, R2 default shape
        tag = mono ? "R5 shape" : (pm ? "R6 shape" : "R2 shape");
        check(tag, miss, 0);
        check("R3/R4 pulse count", rises, zeros);
        check("R8 first rise edge", first, t0 + 7 * div + 1);
    endtask

    initial begin
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h3C};
        int gap = 3;
        int hi;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) step();
        check("R1 reset output", int'(ir_out), 0);
        rst = 1'b0;
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (ir_out) hi++;
        end
        check("R1 idle after reset", hi, 0);

        for (int d = 1; d <= 3; d++)
            for (int m = 0; m < 4; m++)
                for (int p = 0; p < 5; p++) begin
                    run_frame(pats[p], d, m[1], m[0], gap);
                    gap = (gap % 7) + 1;
                end

        // R7: reset in the middle of a pulse
        cur_div = 2;
        short_mode = 1'b0;
        int_src = 1'b1;
        ser_in = 1'b0;
        hi = 0;
        for (int i = 0; i < 200 && ir_out !== 1'b1; i++) step();
        check("R7 pulse reached", int'(ir_out), 1);
        rst = 1'b1;
        ser_in = 1'b1;
        step();
        check("R7 reset clears output", int'(ir_out), 0);
        rst = 1'b0;
        for (int i = 0; i < 80; i++) begin
            step();
            if (ir_out) hi++;
        end
        check("R7 idle after reset", hi, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule